// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block listens to the two lines of an I2C bus and never drives them. It samples SCL and SDA with a system clock that runs many times faster than the bus clock. Each line passes through a synchronizer and a glitch filter. The block then looks for level changes on the filtered lines. From those changes it reports four things: the start of a transfer, a repeated start inside a transfer, the end of a transfer, and every SCL rising edge that clocks a bit while the bus is occupied.

A master that wants to share the bus, or any other observing logic, reads the `busy_o` level before it begins a transfer. `busy_o` rises at a start. It stays high through any number of repeated starts. It falls only after a programmable bus-free time has run out following a stop. Event outputs are registered pulses one clock wide. A bit index travels with each bit pulse, so downstream logic can tell the data bits of a byte from the acknowledge slot.

Top module: `i2c_bus_monitor`

## Requirements
- R1: With SCL steady high, a high-to-low change of SDA produces a one-cycle `start_o` pulse when `busy_o` was low or was counting its free time. `start_o`, `rstart_o` and `stop_o` are never high together.
- R2: With SCL steady high, a low-to-high change of SDA produces a one-cycle `stop_o` pulse.
- R3: A high-to-low SDA change with SCL high while the bus is occupied produces `rstart_o` instead of `start_o`, and `busy_o` stays high without a gap.
- R4: `busy_o` rises in the same cycle as `start_o` and stays high until the free time after a stop has elapsed.
- R5: `busy_o` falls exactly FREE_CYCLES clock cycles after the cycle in which `stop_o` is high, unless a new start arrives first.
- R6: A start detected during the free time, including in the cycle the free time would expire, is reported as `start_o`, not `rstart_o`, and `busy_o` does not fall.
- R7: SDA changes made while SCL is low produce no start, repeated start or stop pulse.
- R8: A new line level is accepted only after it has been present for FILT_LEN consecutive synchronized samples. A shorter SDA pulse while SCL is high produces no condition.
- R9: A condition pulse appears SYNC_STAGES+FILT_LEN+1 rising clock edges after the first edge that samples the changed input.
- R10: Each SCL rising edge while `busy_o` is high gives a one-cycle `bit_o` pulse with `bit_idx_o` holding the bit position. The positions run 0 to FRAME_BITS-1, where 0 to 7 are the data bits, most significant first, and 8 is the acknowledge slot. The index then wraps to 0.
- R11: A start or a repeated start resets the bit position, so the next SCL rising edge reports index 0.
- R12: SCL rising edges while `busy_o` is low produce no `bit_o` pulse.
- R13: After reset all pulse outputs, `busy_o` and `bit_idx_o` are 0, and both lines are taken as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| start_o | output | 1 | Start condition pulse |
| rstart_o | output | 1 | Repeated start pulse |
| stop_o | output | 1 | Stop condition pulse |
| busy_o | output | 1 | Bus occupied, including the free time after a stop |
| bit_o | output | 1 | Bit clocked on an SCL rising edge |
| bit_idx_o | output | $clog2(FRAME_BITS) | Position of the bit just clocked |

## Verification
Two events can land in the same clock cycle: the expiry of the bus-free timer and a newly detected start. The bench holds SCL high and raises SDA to make a stop. It then lowers SDA again after a delay that it sweeps cycle by cycle, from a few cycles before the free time ends to a few cycles after it. For each delay it expects `start_o` and no `rstart_o`. It also counts the cycles in which `busy_o` is low. That count must be zero up to and including the delay equal to the free time, and equal to the excess beyond it for longer delays.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_BUSY = 2'd1,
    BUS_FREE = 2'd2
  } bus_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
  } line_ev_t;

endpackage

// File: rtl/i2cmon_line_filter.sv
module i2cmon_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic level_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   level_q;
  logic                   sampled;

  assign sampled = sync_q[SYNC_STAGES-1];
  assign level_o = level_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b1;
      cnt_q   <= '0;
    end else if (sampled == level_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      level_q <= sampled;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_FILT_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> ($past(sampled) == level_q)); // R8

endmodule

// File: rtl/i2cmon_cond_detect.sv
module i2cmon_cond_detect
  import i2cmon_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_f,
  input  logic     sda_f,
  output line_ev_t ev_o
);
  logic     scl_q, sda_q;
  line_ev_t ev_q;

  assign ev_o = ev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      ev_q  <= '0;
    end else begin
      scl_q         <= scl_f;
      sda_q         <= sda_f;
      ev_q.start    <= scl_f & scl_q & sda_q & ~sda_f;
      ev_q.stop     <= scl_f & scl_q & ~sda_q & sda_f;
      ev_q.scl_rise <= scl_f & ~scl_q;
    end
  end

  AST_RISE_EXCL: assert property (@(posedge clk) disable iff (rst)
    ev_q.scl_rise |-> !(ev_q.start || ev_q.stop)); // R7

endmodule

// File: rtl/i2cmon_bus_tracker.sv
module i2cmon_bus_tracker
  import i2cmon_pkg::*;
#(
  parameter int FREE_CYCLES = 235,
  parameter int FRAME_BITS  = 9,
  localparam int IW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  line_ev_t      ev_i,
  output logic          start_o,
  output logic          rstart_o,
  output logic          stop_o,
  output logic          busy_o,
  output logic          bit_o,
  output logic [IW-1:0] bit_idx_o
);
  localparam int TW = $clog2(FREE_CYCLES + 1);

  bus_state_e    state_q;
  logic [TW-1:0] tmr_q;
  logic [IW-1:0] nxt_q;

  assign busy_o = (state_q != BUS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= BUS_IDLE;
      tmr_q     <= '0;
      nxt_q     <= '0;
      start_o   <= 1'b0;
      rstart_o  <= 1'b0;
      stop_o    <= 1'b0;
      bit_o     <= 1'b0;
      bit_idx_o <= '0;
    end else begin
      start_o  <= 1'b0;
      rstart_o <= 1'b0;
      stop_o   <= ev_i.stop;
      bit_o    <= 1'b0;
      if (ev_i.start) begin
        if (state_q == BUS_BUSY) rstart_o <= 1'b1;
        else                     start_o  <= 1'b1;
        state_q <= BUS_BUSY;
        nxt_q   <= '0;
        tmr_q   <= '0;
      end else if (ev_i.stop) begin
        if (state_q != BUS_IDLE) begin
          state_q <= BUS_FREE;
          tmr_q   <= '0;
        end
      end else if (state_q == BUS_FREE) begin
        if (tmr_q == TW'(FREE_CYCLES - 1)) state_q <= BUS_IDLE;
        else                               tmr_q   <= tmr_q + 1'b1;
      end
      if (ev_i.scl_rise && !ev_i.start && state_q == BUS_BUSY) begin
        bit_o     <= 1'b1;
        bit_idx_o <= nxt_q;
        nxt_q     <= (nxt_q == IW'(FRAME_BITS - 1)) ? '0 : nxt_q + 1'b1;
      end
    end
  end

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_o, rstart_o, stop_o})); // R1
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_o |-> busy_o); // R4
  AST_RSTART_HELD: assert property (@(posedge clk) disable iff (rst)
    rstart_o |-> (busy_o && $past(busy_o))); // R3
  AST_FALL_AFTER_FREE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> ($past(state_q) == BUS_FREE)); // R5
  AST_TMR_RANGE: assert property (@(posedge clk) disable iff (rst)
    tmr_q < TW'(FREE_CYCLES)); // R5
  AST_BIT_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    bit_o |-> busy_o); // R12
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    bit_o |-> (bit_idx_o < IW'(FRAME_BITS))); // R10

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int FREE_CYCLES = 235,
  parameter int FRAME_BITS  = 9,
  localparam int IDX_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             start_o,
  output logic             rstart_o,
  output logic             stop_o,
  output logic             busy_o,
  output logic             bit_o,
  output logic [IDX_W-1:0] bit_idx_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] filt;
  line_ev_t          ev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2cmon_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (raw[g]),
      .level_o(filt[g])
    );
  end

  i2cmon_cond_detect u_det (
    .clk  (clk),
    .rst  (rst),
    .scl_f(filt[1]),
    .sda_f(filt[0]),
    .ev_o (ev)
  );

  i2cmon_bus_tracker #(
    .FREE_CYCLES(FREE_CYCLES),
    .FRAME_BITS (FRAME_BITS)
  ) u_trk (
    .clk      (clk),
    .rst      (rst),
    .ev_i     (ev),
    .start_o  (start_o),
    .rstart_o (rstart_o),
    .stop_o   (stop_o),
    .busy_o   (busy_o),
    .bit_o    (bit_o),
    .bit_idx_o(bit_idx_o)
  );

endmodule

// File: tb/i2c_bus_monitor_bench.sv
`timescale 1ns/1ps
module i2c_bus_monitor_bench;
  localparam int SYNC = 2;
  localparam int FL   = 3;
  localparam int FC   = 20;
  localparam int FB   = 9;
  localparam int LAT  = SYNC + FL + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_i = 1'b1;
  logic sda_i = 1'b1;
  logic start_o, rstart_o, stop_o, busy_o, bit_o;
  logic [3:0] bit_idx_o;

  int cyc = 0;
  int n_start = 0, n_rstart = 0, n_stop = 0, n_bit = 0, n_low = 0;
  int last_start = 0, last_stop = 0, last_fall = 0;
  int idx_log [0:255];
  logic prev_busy = 1'b0;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  i2c_bus_monitor #(.SYNC_STAGES(SYNC), .FILT_LEN(FL), .FREE_CYCLES(FC), .FRAME_BITS(FB))
    u_i2c_bus_monitor (.clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
      .start_o(start_o), .rstart_o(rstart_o), .stop_o(stop_o), .busy_o(busy_o),
      .bit_o(bit_o), .bit_idx_o(bit_idx_o));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (start_o)  begin n_start++;  last_start = cyc; end
      if (rstart_o) n_rstart++;
      if (stop_o)   begin n_stop++;   last_stop = cyc; end
      if (bit_o)    begin idx_log[n_bit % 256] = int'(bit_idx_o); n_bit++; end
      if (!busy_o)  n_low++;
      if (prev_busy && !busy_o) last_fall = cyc;
      prev_busy = busy_o;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    scl_i = 1'b0; tick(4);
    sda_i = b;    tick(4);
    scl_i = 1'b1; tick(8);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1'b1;
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int s0, r0, p0, b0, l0, c0;
    tick(4);
    rst = 1'b0;
    tick(1);
    // R13 reset state
    chk(!start_o && !rstart_o && !stop_o && !bit_o && !busy_o && bit_idx_o == 0,
        "R13 reset", int'(busy_o), 0);

    // R1 R4 R9: start and its latency
    s0 = n_start; c0 = cyc;
    sda_i = 1'b0; tick(12);
    chk(n_start - s0 == 1, "R1 start count", n_start - s0, 1);
    chk(last_start == c0 + LAT, "R9 latency", last_start - c0, LAT);
    chk(busy_o == 1'b1, "R4 busy after start", int'(busy_o), 1);

    // R10 R7: byte A5 then ack 0, then two more bits
    s0 = n_start; r0 = n_rstart; p0 = n_stop; b0 = n_bit;
    for (int i = 7; i >= 0; i--) send_bit(((8'hA5 >> i) & 1) != 0);
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    tick(10);
    chk(n_bit - b0 == 11, "R10 bit count", n_bit - b0, 11);
    for (int i = 0; i < 11; i++)
      chk(idx_log[(b0 + i) % 256] == i % FB, "R10 index", idx_log[(b0 + i) % 256], i % FB);
    chk(n_start == s0 && n_rstart == r0 && n_stop == p0, "R7 data changes", n_stop - p0, 0);

    // R3 R11: repeated start
    l0 = n_low; r0 = n_rstart; s0 = n_start;
    scl_i = 1'b0; tick(4);
    sda_i = 1'b1; tick(4);
    scl_i = 1'b1; tick(8);
    sda_i = 1'b0; tick(12);
    chk(n_rstart - r0 == 1, "R3 rstart count", n_rstart - r0, 1);
    chk(n_start == s0, "R3 no plain start", n_start - s0, 0);
    chk(n_low == l0, "R3 busy held", n_low - l0, 0);
    b0 = n_bit;
    send_bit(1'b1);
    tick(10);
    chk(n_bit - b0 == 1 && idx_log[b0 % 256] == 0, "R11 index reset", idx_log[b0 % 256], 0);

    // R2 R5: stop and free time
    p0 = n_stop;
    scl_i = 1'b0; tick(4);
    sda_i = 1'b0; tick(4);
    scl_i = 1'b1; tick(8);
    c0 = cyc;
    sda_i = 1'b1; tick(FC + 20);
    chk(n_stop - p0 == 1, "R2 stop count", n_stop - p0, 1);
    chk(last_stop == c0 + LAT, "R9 stop latency", last_stop - c0, LAT);
    chk(last_fall - last_stop == FC, "R5 free time", last_fall - last_stop, FC);
    chk(busy_o == 1'b0, "R5 idle", int'(busy_o), 0);

    // R12 R7: SCL toggles and SDA moves while SCL low, bus idle
    b0 = n_bit; s0 = n_start; p0 = n_stop;
    for (int i = 0; i < 4; i++) begin
      scl_i = 1'b0; tick(4);
      sda_i = i[0]; tick(4);
      sda_i = 1'b1; tick(4);
      scl_i = 1'b1; tick(8);
    end
    tick(10);
    chk(n_bit == b0, "R12 no bit while idle", n_bit - b0, 0);
    chk(n_start == s0 && n_stop == p0, "R7 idle data moves", n_start - s0, 0);

    // R8: SDA pulse width sweep with SCL high
    for (int w = 1; w <= FL + 2; w++) begin
      s0 = n_start; p0 = n_stop;
      sda_i = 1'b0; tick(w);
      sda_i = 1'b1; tick(FC + 20);
      chk(n_start - s0 == ((w >= FL) ? 1 : 0), "R8 glitch start", n_start - s0, (w >= FL) ? 1 : 0);
      chk(n_stop - p0 == ((w >= FL) ? 1 : 0), "R8 glitch stop", n_stop - p0, (w >= FL) ? 1 : 0);
    end

    // R6: start landing around free-time expiry
    for (int d = FC - 4; d <= FC + 4; d++) begin
      sda_i = 1'b0; tick(12);
      s0 = n_start; r0 = n_rstart; l0 = n_low;
      sda_i = 1'b1; tick(d);
      sda_i = 1'b0; tick(12);
      chk(n_start - s0 == 1, "R6 start reported", n_start - s0, 1);
      chk(n_rstart == r0, "R6 no rstart", n_rstart - r0, 0);
      chk(n_low - l0 == ((d > FC) ? d - FC : 0), "R6 busy gap", n_low - l0, (d > FC) ? d - FC : 0);
      sda_i = 1'b1; tick(FC + 20);
    end

    finish_run();
  end

endmodule